// File: doc/BRIEF.md
# Prescaled Free-Running Interval Timer

An 8-bit up-counter that runs for as long as the clock runs. A free-running binary divider produces count pulses, and a 3-bit select code chooses which divider stage drives the counter, from one pulse per 8 clocks to one per 1024 clocks. Each wrap of the count from FFh to 00h raises a sticky interrupt request. It also emits a one-cycle tick that serves as the time base for an external watchdog counter.

Software reaches the block through a single register location. A read returns the live count. A write loads a control byte. That byte carries the prescale select, three stored mode bits for neighbouring power and watchdog logic, and a counter-clear bit. The clear bit acts as a one-cycle pulse and drops by itself, so the counter restarts from zero and never halts.

Top module: `intv_timer`

## Requirements
- R1: The count is 8 bits wide. It rises by exactly one on each prescaler tick and holds between ticks. No input stops it.
- R2: Control bits [2:0] hold the select code n. The counter is then stepped once every 2^(n+3) clocks, so code 000 divides by 8 and 111 by 1024. The divider runs from reset and a clear does not restart it, so with code 000 after reset the count first reads 1 after the eighth rising edge.
- R3: When a tick moves the count from FFh to 00h, irq_o is high from the following cycle onward.
- R4: A write with control bit 3 set forces the count to 0 on the second rising edge after the write cycle. Counting then resumes from 0.
- R5: The clear pulse lasts one cycle unless it is written again. When the clear and a wrapping tick fall in the same cycle, the clear wins, the count goes to 0, and neither irq_o nor wdt_tick_o is raised.
- R6: While bus_cs_i is high and bus_we_i is low, bus_rdata_o shows the count. In every other cycle it shows 0.
- R7: A write stores control bit 4 on cfg_wakeup_o, bit 5 on cfg_rcwdt_o and bit 6 on cfg_wdt_en_o from the next cycle. Bit 7 is ignored.
- R8: irq_o stays high until irq_ack_i is seen high in a cycle with no wrap. A wrap in the same cycle as an acknowledge leaves irq_o high.
- R9: wdt_tick_o is high for exactly one cycle per wrap, in the same cycle that irq_o is first set.
- R10: During reset the count, irq_o, wdt_tick_o and all three cfg outputs are 0, and the select code is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cs_i | input | 1 | Register location selected |
| bus_we_i | input | 1 | 1 = write control byte, 0 = read count |
| bus_wdata_i | input | 8 | Control byte written |
| bus_rdata_o | output | 8 | Count value on a read, 0 otherwise |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Sticky wrap interrupt request |
| wdt_tick_o | output | 1 | One-cycle pulse per wrap, toward a watchdog |
| cfg_wakeup_o | output | 1 | Stored wake-up mode bit |
| cfg_rcwdt_o | output | 1 | Stored RC watchdog mode bit |
| cfg_wdt_en_o | output | 1 | Stored watchdog enable bit |

## Verification
The bench builds the block with its default parameters: an 8-bit count and a 3-bit select over a 10-stage divider. Wraps at divide-by-8 and divide-by-16 occur every 2048 and 4096 clocks, so many wraps, acknowledge collisions and clear-on-wrap collisions fit within the run. Divide-by-1024 is reached only for its first few ticks, which is enough to confirm stage selection and cadence at the top of the divider.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned CTRL_CLR_BIT   = 3;
  localparam int unsigned CTRL_WAKE_BIT  = 4;
  localparam int unsigned CTRL_RCWDT_BIT = 5;
  localparam int unsigned CTRL_WDTEN_BIT = 6;

  typedef struct packed {
    logic wakeup;
    logic rcwdt;
    logic wdt_en;
  } ivt_cfg_t;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned DIV_BASE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned N_STAGE = 1 << SEL_W;
  localparam int unsigned DIV_W   = DIV_BASE + N_STAGE - 1;

  logic [DIV_W-1:0]   div_q;
  logic [N_STAGE-1:0] stage_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // stage k fires once per 2^(DIV_BASE+k) clocks
  for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
    assign stage_tick[k] = &div_q[DIV_BASE+k-1:0];
  end

  assign tick_o = stage_tick[sel_i];
endmodule

// File: rtl/ivt_ctrl_reg.sv
module ivt_ctrl_reg
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              clr_o,
  output ivt_cfg_t          cfg_o
);
  logic [SEL_W-1:0] sel_q;
  logic             clr_q;
  ivt_cfg_t         cfg_q;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:CTRL_WDTEN_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cfg_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= wr_i & wdata_i[CTRL_CLR_BIT];  // self-clearing pulse
      if (wr_i) begin
        sel_q        <= wdata_i[SEL_W-1:0];
        cfg_q.wakeup <= wdata_i[CTRL_WAKE_BIT];
        cfg_q.rcwdt  <= wdata_i[CTRL_RCWDT_BIT];
        cfg_q.wdt_en <= wdata_i[CTRL_WDTEN_BIT];
      end
    end
  end

  assign sel_o = sel_q;
  assign clr_o = clr_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, wrap_q, ovf;

  // clear beats a wrapping tick
  assign ovf = tick_i & ~clr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (ovf)         irq_q <= 1'b1;
      else if (ack_i)  irq_q <= 1'b0;
      wrap_q <= ovf;
    end
  end

  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned DIV_BASE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_cs_i,
  input  logic             bus_we_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  input  logic             irq_ack_i,
  output logic             irq_o,
  output logic             wdt_tick_o,
  output logic             cfg_wakeup_o,
  output logic             cfg_rcwdt_o,
  output logic             cfg_wdt_en_o
);
  logic [SEL_W-1:0] sel;
  logic             clr_pulse, pre_tick, wr_en, rd_en;
  logic [CNT_W-1:0] cnt;
  ivt_cfg_t         cfg;

  assign wr_en = bus_cs_i & bus_we_i;
  assign rd_en = bus_cs_i & ~bus_we_i;

  ivt_ctrl_reg #(.DATA_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_en), .wdata_i(bus_wdata_i),
    .sel_o(sel), .clr_o(clr_pulse), .cfg_o(cfg)
  );

  ivt_prescaler #(.SEL_W(SEL_W), .DIV_BASE(DIV_BASE)) u_pre (
    .clk_i, .rst_ni, .sel_i(sel), .tick_o(pre_tick)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(pre_tick), .clr_i(clr_pulse), .ack_i(irq_ack_i),
    .cnt_o(cnt), .irq_o, .wrap_o(wdt_tick_o)
  );

  assign bus_rdata_o  = rd_en ? cnt : '0;
  assign cfg_wakeup_o = cfg.wakeup;
  assign cfg_rcwdt_o  = cfg.rcwdt;
  assign cfg_wdt_en_o = cfg.wdt_en;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             we_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i,
  input logic             clr_i,
  input logic             ack_i,
  input logic             irq_i,
  input logic             wdt_i
);
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_i));
  p_wrap_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && (&cnt_i)) |=> (irq_i && wdt_i && cnt_i == '0));
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_i == '0);
  p_clr_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(cs_i && we_i && wdata_i[3])) |=> !clr_i);
  p_no_wrap_on_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !wdt_i);
  p_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i) |-> rdata_i == cnt_i);
  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !ack_i) |=> irq_i);
  p_wdt_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_i |=> !wdt_i);
  p_wdt_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_i |-> irq_i);
endmodule

bind intv_timer ivt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(bus_cs_i), .we_i(bus_we_i),
  .wdata_i(bus_wdata_i), .rdata_i(bus_rdata_o), .cnt_i(cnt),
  .tick_i(pre_tick), .clr_i(clr_pulse), .ack_i(irq_ack_i),
  .irq_i(irq_o), .wdt_i(wdt_tick_o)
);

// File: tb/intv_timer_bench.sv
module intv_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wdt, c_wake, c_rc, c_wen;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  intv_timer u_intv_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_cs_i(cs), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_ack_i(ack),
    .irq_o(irq), .wdt_tick_o(wdt), .cfg_wakeup_o(c_wake),
    .cfg_rcwdt_o(c_rc), .cfg_wdt_en_o(c_wen)
  );

  // reference model built from the requirements
  logic [9:0] m_div = '0;
  logic [7:0] m_cnt = '0;
  logic [2:0] m_sel = '0, m_cfg = '0;
  logic       m_irq = 1'b0, m_wdt = 1'b0, m_clr = 1'b0;

  function automatic logic next_tick(logic [9:0] d, logic [2:0] s);
    int mask;
    mask = (1 << (int'(s) + 3)) - 1;
    return (int'(d) & mask) == mask;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = '0; m_cnt = '0; m_sel = '0; m_cfg = '0;
      m_irq = 1'b0; m_wdt = 1'b0; m_clr = 1'b0;
    end else begin
      logic t, ovf;
      t   = next_tick(m_div, m_sel);
      ovf = t && !m_clr && (m_cnt == 8'hFF);
      if (m_clr)  m_cnt = '0;
      else if (t) m_cnt = m_cnt + 8'd1;
      if (ovf)      m_irq = 1'b1;
      else if (ack) m_irq = 1'b0;
      m_wdt = ovf;
      m_clr = cs && we && wdata[3];
      if (cs && we) begin
        m_sel = wdata[2:0];
        m_cfg = {wdata[4], wdata[5], wdata[6]};
      end
      m_div = m_div + 10'd1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle at the negedge, check all outputs against the model
  task automatic cyc(logic c, logic w, logic [7:0] d, logic a, string tag);
    cs = c; we = w; wdata = d; ack = a;
    #1;
    chk({tag, " R6 rdata"}, int'(rdata), (c && !w) ? int'(m_cnt) : 0);
    chk({tag, " R8 irq"}, int'(irq), int'(m_irq));
    chk({tag, " R9 wdt"}, int'(wdt), int'(m_wdt));
    chk({tag, " R7 cfg"}, int'({c_wake, c_rc, c_wen}), int'(m_cfg));
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    cs = 1'b1;
    #2;
    // R10: reset state
    chk("R10 count", int'(rdata), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 wdt", int'(wdt), 0);
    chk("R10 cfg", int'({c_wake, c_rc, c_wen}), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R2: divide-by-8 after reset, first step after eight edges
    idle(8, "R2 div8 pre");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, "R2 first");
    chk("R2 first step", int'(rdata), 1);  // rdata still driven by last read
    idle(40, "R1 div8 run");

    // R7: cfg bits stored, bit 7 ignored, select 000 kept
    cyc(1'b1, 1'b1, 8'hF0, 1'b0, "R7 write");
    idle(4, "R7 after");
    chk("R7 all set", int'({c_wake, c_rc, c_wen}), 7);
    cyc(1'b1, 1'b1, 8'h20, 1'b0, "R7 write2");
    idle(2, "R7 after2");
    chk("R7 rcwdt only", int'({c_wake, c_rc, c_wen}), 3'b010);

    // R2: divide-by-1024 with clear
    cyc(1'b1, 1'b1, 8'h0F, 1'b0, "R2 sel7");
    idle(3100, "R2 div1024");
    chk("R2 div1024 count", int'(m_cnt), 3);

    // R4: clear at an arbitrary value, select divide-by-8
    cyc(1'b1, 1'b1, 8'h00, 1'b0, "R4 sel0");
    idle(100, "R4 run");
    cyc(1'b1, 1'b1, 8'h08, 1'b0, "R4 clr");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, "R4 pulse");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, "R4 zero");
    idle(20, "R4 resume");

    // R3 / R9: run to a wrap
    while (!m_irq) cyc(1'b1, 1'b0, 8'h00, 1'b0, "R3 to wrap");
    chk("R3 irq set", int'(irq), 1);
    idle(30, "R8 hold");
    chk("R8 held", int'(irq), 1);
    cyc(1'b1, 1'b0, 8'h00, 1'b1, "R8 ack");
    chk("R8 cleared", int'(m_irq), 0);

    // R8: wrap and ack in the same cycle
    while (!(m_cnt == 8'hFF && next_tick(m_div, m_sel) && !m_clr))
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R8 approach");
    cyc(1'b1, 1'b0, 8'h00, 1'b1, "R8 collide");
    idle(2, "R8 post");
    chk("R8 wrap beats ack", int'(irq), 1);
    cyc(1'b1, 1'b0, 8'h00, 1'b1, "R8 ack2");

    // R5: clear coincides with wrapping tick
    while (!(m_cnt == 8'hFF && next_tick(m_div + 10'd1, m_sel)))
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R5 approach");
    cyc(1'b1, 1'b1, 8'h08, 1'b0, "R5 clr");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, "R5 collide");
    idle(3, "R5 post");
    chk("R5 no irq", int'(irq), 0);
    chk("R5 count", int'(m_cnt), 0);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom % 400);
      d = 8'($urandom);
      d[2:0] = {2'b00, d[0]};
      if (r == 0)
        cyc(1'b1, 1'b1, d, 1'b0, "RND wr");
      else if (r < 30)
        cyc(1'b1, 1'b0, 8'h00, 1'b1, "RND ack");
      else if (r < 50)
        cyc(1'b0, 1'b0, 8'h00, 1'b0, "RND idle");
      else
        cyc(1'b1, 1'b0, 8'h00, 1'b0, "RND rd");
    end
    finish_run();
  end
endmodule